// File: doc/BRIEF.md
# Interrupt Status Aggregation Register

This block collects interrupt events for a USB peripheral controller into one 32-bit status word that a host microprocessor reads over a simple register bus. Single-cycle pulses from the endpoint buffers, from the bus-state monitor and from the DMA engine set sticky bits. Each bit stays set until the host writes a one to it. A level interrupt line is high whenever any status bit is set.

DMA causes are kept in a second, 8-bit reason register. The status word holds only one DMA summary bit. To fully acknowledge a DMA interrupt, the host clears the cause in the reason register and then clears the summary bit. If the summary bit is cleared while a cause is still recorded, the summary bit comes back. The register bus has a one-bit address, a write strobe with write data, and a read-data output that follows the address combinationally.

Top module: `usb_irq_status`

## Requirements
- R1: After synchronous reset, the status word (address 0) reads 0x00000000, the reason register (address 1) reads 0x00, and irq_o is low.
- R2: A pulse on ep_rx_evt[i] sets status bit 16+2i, and a pulse on ep_tx_evt[i] sets status bit 17+2i, for endpoints i = 0..7. The new value is visible on the first cycle after the pulse.
- R3: The bus_evt pulses map to status bits 0..4 in this order: bit 0 bus reset, bit 1 resume, bit 2 suspend, bit 3 pseudo-SOF, bit 4 SOF.
- R4: A status or reason bit stays set until the host writes 1 to it. Writing 1 clears the bit on the next clock edge. Writing 0 leaves the bit unchanged.
- R5: When a hardware set and a host clear reach the same bit in the same cycle, the bit ends up set.
- R6: Status bits 6..15 always read 0, and writes to them have no effect.
- R7: A pulse on dma_evt[k] sets reason bit k (address 1, bits 7:0) and status bit 5 (the DMA summary) on the next clock edge.
- R8: If the host clears status bit 5 while any reason bit is still set, bit 5 reads 0 for one cycle and is set again on the cycle after. Once the reason register is empty, clearing bit 5 keeps it clear.
- R9: irq_o is a registered output. It is high in exactly those cycles in which the status word is non-zero, so it falls on the same clock edge that clears the last set bit.
- R10: reg_addr 0 selects the status word and reg_addr 1 selects the reason register, for both reads and writes. rd_data follows reg_addr with no clock delay, and reason reads are zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_tx_evt | input | 8 | Per-endpoint transmit event pulses |
| ep_rx_evt | input | 8 | Per-endpoint receive event pulses |
| bus_evt | input | 5 | Bus-state event pulses (reset, resume, suspend, pseudo-SOF, SOF) |
| dma_evt | input | 8 | DMA cause pulses |
| reg_addr | input | 1 | Register select: 0 status, 1 reason |
| reg_we | input | 1 | Write strobe (write-one-to-clear) |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Level interrupt request |

## Verification
Single-event walks drive one endpoint, bus or DMA pulse at a time. They show whether each source lands on its own bit position. Clear writes that mix ones and zeros separate write-one-to-clear behaviour from plain overwrite. Set and clear are then aimed at the same bit in the same cycle to expose the priority rule, and writes to the reserved range show whether those bits stay zero. The DMA acknowledge is tried in both orders, summary first and reason first, so the re-assertion of the summary bit is exercised. A long run of sparse random events mixed with random clears compares both registers and the interrupt line every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_EP    = 8;
    localparam int EP_IDX_W  = $clog2(NUM_EP);
    localparam int NUM_BEV   = 5;
    localparam int REASON_W  = 8;
    localparam int STAT_W    = 32;
    localparam int EP_BASE   = 16;
    localparam int EP_BITS   = 2 * NUM_EP;
    localparam int DMA_POS   = 5;

    typedef enum int {
        BEV_BUSRST = 0,
        BEV_RESUME = 1,
        BEV_SUSP   = 2,
        BEV_PSOF   = 3,
        BEV_SOF    = 4
    } bev_pos_e;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_REASON = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [STAT_W-1:0] data;
    } reg_wr_t;

    function automatic int ep_rx_pos(input int idx);
        return EP_BASE + 2 * idx;
    endfunction

    function automatic int ep_tx_pos(input int idx);
        return EP_BASE + 2 * idx + 1;
    endfunction
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb nxt_o[b] = set_i[b] | (q[b] & ~clr_i[b]);
        always_ff @(posedge clk) begin
            if (rst) q[b] <= 1'b0;
            else     q[b] <= nxt_o[b];
        end
    end

    assign q_o = q;

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(q) & ~$past(clr_i)) & ~q) == '0));

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_dma_summary.sv
module irq_dma_summary (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic reason_any_i,
    output logic q_o,
    output logic nxt_o
);
    logic q;

    always_comb nxt_o = set_i | (q & ~clr_i) | (~q & reason_any_i);

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= nxt_o;
    end

    assign q_o = q;

    // R7
    dma_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q);

    // R8
    dma_reassert_chk: assert property (@(posedge clk) disable iff (rst)
        (!q && reason_any_i) |=> q);
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_EP-1:0]   ep_tx_evt,
    input  logic [NUM_EP-1:0]   ep_rx_evt,
    input  logic [NUM_BEV-1:0]  bus_evt,
    input  logic [REASON_W-1:0] dma_evt,
    input  logic                reg_addr,
    input  logic                reg_we,
    input  logic [STAT_W-1:0]   reg_wdata,
    output logic [STAT_W-1:0]   rd_data,
    output logic                irq_o
);
    reg_wr_t wr;
    logic [STAT_W-1:0]   stat_clr;
    logic [REASON_W-1:0] rsn_clr;
    logic [EP_BITS-1:0]  ep_set, ep_q, ep_nxt;
    logic [NUM_BEV-1:0]  bev_q, bev_nxt;
    logic [REASON_W-1:0] rsn_q, rsn_nxt;
    logic                sum_q, sum_nxt;
    logic [STAT_W-1:0]   status_word;
    logic                irq_q;

    always_comb begin
        wr.we   = reg_we;
        wr.sel  = reg_sel_e'(reg_addr);
        wr.data = reg_wdata;
        stat_clr = (wr.we && wr.sel == SEL_STATUS) ? wr.data : '0;
        rsn_clr  = (wr.we && wr.sel == SEL_REASON) ? wr.data[REASON_W-1:0] : '0;
    end

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        assign ep_set[ep_rx_pos(i) - EP_BASE] = ep_rx_evt[i];
        assign ep_set[ep_tx_pos(i) - EP_BASE] = ep_tx_evt[i];
    end

    irq_sticky_bank #(.W(EP_BITS)) u_ep_bank (
        .clk(clk), .rst(rst),
        .set_i(ep_set),
        .clr_i(stat_clr[EP_BASE +: EP_BITS]),
        .q_o(ep_q), .nxt_o(ep_nxt)
    );

    irq_sticky_bank #(.W(NUM_BEV)) u_bev_bank (
        .clk(clk), .rst(rst),
        .set_i(bus_evt),
        .clr_i(stat_clr[NUM_BEV-1:0]),
        .q_o(bev_q), .nxt_o(bev_nxt)
    );

    irq_sticky_bank #(.W(REASON_W)) u_rsn_bank (
        .clk(clk), .rst(rst),
        .set_i(dma_evt),
        .clr_i(rsn_clr),
        .q_o(rsn_q), .nxt_o(rsn_nxt)
    );

    irq_dma_summary u_dma_sum (
        .clk(clk), .rst(rst),
        .set_i(|dma_evt),
        .clr_i(stat_clr[DMA_POS]),
        .reason_any_i(|rsn_q),
        .q_o(sum_q), .nxt_o(sum_nxt)
    );

    always_comb begin
        status_word = '0;
        status_word[EP_BASE +: EP_BITS] = ep_q;
        status_word[NUM_BEV-1:0]        = bev_q;
        status_word[DMA_POS]            = sum_q;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= (|ep_nxt) | (|bev_nxt) | sum_nxt;
    end

    logic unused_rsn_nxt;
    assign unused_rsn_nxt = ^rsn_nxt;

    assign irq_o   = irq_q;
    assign rd_data = (reg_sel_e'(reg_addr) == SEL_REASON)
                   ? {{(STAT_W-REASON_W){1'b0}}, rsn_q} : status_word;

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q == (status_word != '0));
endmodule

// File: tb/usb_irq_status_test.sv
module usb_irq_status_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  ep_tx_evt, ep_rx_evt, dma_evt;
    logic [4:0]  bus_evt;
    logic        reg_addr, reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] rd_data;
    logic        irq_o;

    usb_irq_status uut (
        .clk(clk), .rst(rst), .ep_tx_evt(ep_tx_evt), .ep_rx_evt(ep_rx_evt),
        .bus_evt(bus_evt), .dma_evt(dma_evt), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .rd_data(rd_data), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    string cur_req = "R1";

    logic [31:0] m_st;
    logic [7:0]  m_rs;
    logic        m_irq;

    // Behavioural reference updated on each rising edge
    always @(posedge clk) begin
        logic [31:0] clr;
        logic [7:0]  rclr;
        logic [31:0] nst;
        logic        old_sum;
        logic        rs_any;
        cycles++;
        if (rst) begin
            m_st = 0; m_rs = 0; m_irq = 0;
        end else begin
            clr  = (reg_we && !reg_addr) ? reg_wdata : 32'h0;
            rclr = (reg_we && reg_addr) ? reg_wdata[7:0] : 8'h0;
            rs_any  = (m_rs != 0);
            old_sum = m_st[5];
            nst = m_st & ~clr;
            for (int i = 0; i < 8; i++) begin
                if (ep_rx_evt[i]) nst[16+2*i] = 1'b1;
                if (ep_tx_evt[i]) nst[17+2*i] = 1'b1;
            end
            for (int b = 0; b < 5; b++) if (bus_evt[b]) nst[b] = 1'b1;
            if (dma_evt != 0) nst[5] = 1'b1;
            else if (!old_sum && rs_any) nst[5] = 1'b1;
            nst[15:6] = 10'h0;
            m_st  = nst;
            m_rs  = (m_rs & ~rclr) | dma_evt;
            m_irq = (m_st != 0);
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic saved;
        saved = reg_addr;
        reg_addr = 1'b0; #1;
        check("status", rd_data, m_st);
        reg_addr = 1'b1; #1;
        check("reason", rd_data, {24'h0, m_rs});
        check("irq", {31'h0, irq_o}, {31'h0, m_irq});
        reg_addr = saved;
    endtask

    task automatic idle_inputs();
        ep_tx_evt = 0; ep_rx_evt = 0; bus_evt = 0; dma_evt = 0;
        reg_we = 0; reg_addr = 0; reg_wdata = 0;
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        idle_inputs();
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        step();
    endtask

    task automatic peek(input string what, input logic a, input logic [31:0] exp);
        logic saved;
        saved = reg_addr;
        reg_addr = a; #1;
        check(what, rd_data, exp);
        reg_addr = saved;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        compare();
        peek("reset status", 1'b0, 32'h0);
        rst = 1'b0;
        step();

        // R2 endpoint walk
        cur_req = "R2";
        for (int i = 0; i < 8; i++) begin
            ep_rx_evt[i] = 1'b1; step();
            peek("ep rx bit", 1'b0, 32'h1 << (16 + 2*i));
            wr(1'b0, 32'hFFFF_FFFF);
            ep_tx_evt[i] = 1'b1; step();
            peek("ep tx bit", 1'b0, 32'h1 << (17 + 2*i));
            wr(1'b0, 32'hFFFF_FFFF);
        end

        // R3 bus event walk
        cur_req = "R3";
        for (int b = 0; b < 5; b++) begin
            bus_evt[b] = 1'b1; step();
            peek("bus bit", 1'b0, 32'h1 << b);
            wr(1'b0, 32'h1 << b);
        end

        // R4 write-one-to-clear, zeros ignored
        cur_req = "R4";
        bus_evt = 5'h1F; ep_tx_evt = 8'hFF; step();
        wr(1'b0, 32'h0);
        peek("zero write", 1'b0, 32'hAAAA_001F);
        wr(1'b0, 32'h0000_0005);
        peek("partial clear", 1'b0, 32'hAAAA_001A);
        repeat (3) step();
        wr(1'b0, 32'hFFFF_FFFF);

        // R5 set beats clear on same bit
        cur_req = "R5";
        bus_evt[2] = 1'b1; ep_rx_evt[3] = 1'b1;
        reg_addr = 1'b0; reg_we = 1'b1; reg_wdata = 32'hFFFF_FFFF;
        step();
        peek("set wins", 1'b0, 32'h0040_0004);
        wr(1'b0, 32'hFFFF_FFFF);

        // R6 reserved bits
        cur_req = "R6";
        bus_evt = 5'h1F; step();
        wr(1'b0, 32'h0000_FFC0);
        peek("reserved", 1'b0, 32'h0000_001F);
        wr(1'b0, 32'hFFFF_FFFF);

        // R7 DMA cause sets reason and summary
        cur_req = "R7";
        dma_evt = 8'h24; step();
        peek("summary", 1'b0, 32'h0000_0020);
        peek("reason", 1'b1, 32'h0000_0024);

        // R8 summary-first clear bounces back
        cur_req = "R8";
        wr(1'b0, 32'h0000_0020);
        peek("summary cleared", 1'b0, 32'h0);
        step();
        peek("summary back", 1'b0, 32'h0000_0020);
        // reason first, then summary: stays clear
        cur_req = "R10";
        wr(1'b1, 32'h0000_0024);
        peek("reason cleared", 1'b1, 32'h0);
        cur_req = "R8";
        wr(1'b0, 32'h0000_0020);
        step(); step();
        peek("summary stays clear", 1'b0, 32'h0);

        // R9 irq drops with last bit
        cur_req = "R9";
        ep_tx_evt[7] = 1'b1; step();
        check("irq set", {31'h0, irq_o}, 32'h1);
        wr(1'b0, 32'h8000_0000);
        check("irq clear", {31'h0, irq_o}, 32'h0);

        // Mixed random traffic (R4 R5 R7 R8 R10)
        cur_req = "R4";
        for (int n = 0; n < 3000; n++) begin
            ep_tx_evt = 8'($urandom & $urandom & $urandom);
            ep_rx_evt = 8'($urandom & $urandom & $urandom);
            bus_evt   = 5'($urandom & $urandom & $urandom);
            dma_evt   = 8'($urandom & $urandom & $urandom & $urandom);
            reg_we    = ($urandom % 3) == 0;
            reg_addr  = 1'($urandom);
            reg_wdata = $urandom;
            @(negedge clk);
            compare();
        end
        idle_inputs();
        step();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule